// File: doc/BRIEF.md
# Neuron Operand Store and Address Sequencer

This block holds the local operands of one neuron element and steps through them in order. A forward pair of banks stores incoming input states and their weights. A backward pair stores incoming errors and their weights. A parameter removes the backward pair completely. The bus side writes each bank through its own write pointer. The execution side asks for operands one pair at a time, and gets an (input, weight) pair back from the bank pair that the current phase selects.

One read counter serves both phases. Each phase has its own end-count register. A read is granted only when both banks of the active pair already hold the requested entry. The execution side can therefore start as soon as the first input has arrived, while later inputs are still being written. When the last entry of a phase is returned, a one-cycle done pulse goes with it. The counter then returns to zero, and the input bank of that phase is emptied so that it can take the next data set. The weights stay in place.

The execution side can write an updated weight back to the entry it was handed last. This update goes to the weight bank of the phase that produced that entry.

Top module: `nmem_addr_unit`

## Requirements
- R1: After a synchronous active-high reset, `rd_vld_o` and `done_o` are low. The read counter and all write pointers are zero, so the first granted read returns entry 0.
- R2: `wr_kind_i` selects the bank being written: 0 = forward inputs, 1 = forward weights, 2 = backward inputs, 3 = backward weights. Each bank's writes fill consecutive entries starting at 0. The read counter hands out entries in increasing order, and the returned input and weight come from the same entry.
- R3: A read request is granted only when the read index is below the number of entries written into both the input bank and the weight bank of the active phase. A request that is not granted produces no `rd_vld_o` and leaves the counter unchanged.
- R4: A granted request in cycle t gives `rd_vld_o`, `rd_addr_o`, `rd_in_o` and `rd_wt_o` in cycle t+1. `rd_vld_o` is never high without a request in the cycle before.
- R5: A bus write and a granted read can happen in the same cycle. An entry written in cycle t can be read by a request in cycle t+1.
- R6: When the granted read's index equals the active limit minus one, `done_o` is high together with that pair's `rd_vld_o`. The counter restarts at 0, and the input-bank write pointer of that phase clears to 0. The weight pointers keep their values.
- R7: A write to an input bank whose pointer already equals its phase limit is ignored. A write to a weight bank whose pointer equals the bank depth is ignored.
- R8: `lim_ld_i` loads the forward limit from `lim_fwd_i` and the backward limit from `lim_bwd_i`. The forward phase (`phase_i`=0) ends at the forward limit and the backward phase (`phase_i`=1) ends at the backward limit.
- R9: With `wu_en_i` high, `wu_data_i` is written into the weight bank of the phase of the last returned pair, at `rd_addr_o`. A bus write to that same weight bank in the same cycle is dropped, and its pointer does not advance.
- R10: In the backward phase, reads return (backward input, backward weight) pairs.
- R11: With BACKPROP_EN=0, `phase_i` is ignored and every read uses the forward pair. Writes of kind 2 or 3 are ignored.
- R12: A change of the active phase resets the read counter to 0. A request in the cycle of the change is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_kind_i | input | 2 | Target bank of the write (see R2) |
| wr_data_i | input | DATA_W | Bus write data |
| lim_ld_i | input | 1 | Load both phase limits |
| lim_fwd_i | input | ADDR_W+1 | Number of forward inputs |
| lim_bwd_i | input | ADDR_W+1 | Number of backward inputs |
| phase_i | input | 1 | 0 forward, 1 backward |
| rd_req_i | input | 1 | Operand pair request |
| rd_vld_o | output | 1 | Returned pair valid |
| rd_addr_o | output | ADDR_W | Entry index of the returned pair |
| rd_in_o | output | DATA_W | Returned input state or error |
| rd_wt_o | output | DATA_W | Returned weight |
| done_o | output | 1 | Last pair of the phase |
| wu_en_i | input | 1 | Weight update strobe |
| wu_data_i | input | DATA_W | Updated weight |

## Verification
If the read counter drifts, the very next returned pair shows it: the address is out of sequence, or the input and weight values are paired wrongly. If a write pointer is off, a read stalls or is granted one cycle too early, or later data appears at a shifted entry. If an input pointer is not cleared after done, the next pass stalls or returns stale inputs. If an update or a dropped bus write goes to the wrong place, the damage stays hidden until that weight entry is read in a later pass. The bench therefore reads every updated entry again.

// File: rtl/nmem_pkg.sv
package nmem_pkg;

  // Bank selector carried on the write port
  typedef enum logic [1:0] {
    KIND_FWD_IN = 2'd0,
    KIND_FWD_WT = 2'd1,
    KIND_BWD_IN = 2'd2,
    KIND_BWD_WT = 2'd3
  } wr_kind_e;

  localparam int NUM_BANKS_MAX = 4;

  // Number of instantiated banks for a given learning option
  function automatic int bank_count(input bit bwd_en);
    return bwd_en ? 4 : 2;
  endfunction

endpackage

// File: rtl/nmem_bank.sv
module nmem_bank #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/nmem_wr_ptr.sv
module nmem_wr_ptr #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (inc_i)   cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/nmem_rd_seq.sv
module nmem_rd_seq #(
  parameter int ADDR_W = 6,
  parameter bit BWD_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lim_ld_i,
  input  logic [ADDR_W:0]   lim_fwd_i,
  input  logic [ADDR_W:0]   lim_bwd_i,
  input  logic              phase_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] idx_o,
  output logic              last_o,
  output logic              chg_o,
  output logic [ADDR_W:0]   lim_fwd_o,
  output logic [ADDR_W:0]   lim_bwd_o
);
  localparam int CNT_W = ADDR_W + 1;

  logic             phase_q;
  logic [CNT_W-1:0] lim_act;

  always_ff @(posedge clk) begin
    if (rst)           lim_fwd_o <= '0;
    else if (lim_ld_i) lim_fwd_o <= lim_fwd_i;
  end

  // Backward end-count register only when learning is built in
  generate
    if (BWD_EN) begin : g_bwd_lim
      always_ff @(posedge clk) begin
        if (rst)           lim_bwd_o <= '0;
        else if (lim_ld_i) lim_bwd_o <= lim_bwd_i;
      end
    end else begin : g_no_bwd_lim
      assign lim_bwd_o = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) phase_q <= 1'b0;
    else     phase_q <= phase_i;
  end

  assign chg_o   = (phase_i != phase_q);
  assign lim_act = phase_i ? lim_bwd_o : lim_fwd_o;
  assign last_o  = ({1'b0, idx_o} + CNT_W'(1)) == lim_act;

  always_ff @(posedge clk) begin
    if (rst || chg_o) idx_o <= '0;
    else if (step_i)  idx_o <= last_o ? '0 : idx_o + ADDR_W'(1);
  end

endmodule

// File: rtl/nmem_addr_unit.sv
module nmem_addr_unit #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter bit BACKPROP_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lim_ld_i,
  input  logic [ADDR_W:0]   lim_fwd_i,
  input  logic [ADDR_W:0]   lim_bwd_i,
  input  logic              phase_i,
  input  logic              rd_req_i,
  output logic              rd_vld_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [DATA_W-1:0] rd_in_o,
  output logic [DATA_W-1:0] rd_wt_o,
  output logic              done_o,
  input  logic              wu_en_i,
  input  logic [DATA_W-1:0] wu_data_i
);
  import nmem_pkg::*;

  localparam int CNT_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = bank_count(BACKPROP_EN);

  logic              phase_act;
  logic [ADDR_W-1:0] rd_idx;
  logic              rd_last;
  logic              ph_chg;
  logic [CNT_W-1:0]  lim_fwd, lim_bwd;
  logic              step;
  logic              done_evt;
  logic              rd_ph_q;
  logic [CNT_W-1:0]  cnt  [NUM_BANKS_MAX];
  logic [DATA_W-1:0] rdat [NUM_BANKS_MAX];
  logic [CNT_W-1:0]  in_cnt_act, wt_cnt_act;

  assign phase_act = BACKPROP_EN ? phase_i : 1'b0;

  nmem_rd_seq #(
    .ADDR_W (ADDR_W),
    .BWD_EN (BACKPROP_EN)
  ) u_rd_seq (
    .clk       (clk),
    .rst       (rst),
    .lim_ld_i  (lim_ld_i),
    .lim_fwd_i (lim_fwd_i),
    .lim_bwd_i (lim_bwd_i),
    .phase_i   (phase_act),
    .step_i    (step),
    .idx_o     (rd_idx),
    .last_o    (rd_last),
    .chg_o     (ph_chg),
    .lim_fwd_o (lim_fwd),
    .lim_bwd_o (lim_bwd)
  );

  // Grant: entry must be present in both banks of the active pair
  assign in_cnt_act = phase_act ? cnt[2] : cnt[0];
  assign wt_cnt_act = phase_act ? cnt[3] : cnt[1];
  assign step       = rd_req_i && !ph_chg
                      && ({1'b0, rd_idx} < in_cnt_act)
                      && ({1'b0, rd_idx} < wt_cnt_act);
  assign done_evt   = step && rd_last;

  generate
    for (genvar b = 0; b < NUM_BANKS_MAX; b++) begin : g_bank
      localparam bit PH    = (b / 2) == 1;
      localparam bit IS_WT = (b % 2) == 1;
      if (b < NB) begin : g_on
        logic              hit, acc, full, clr, we;
        logic [ADDR_W-1:0] waddr;
        logic [DATA_W-1:0] wdata;

        assign hit = wr_en_i && (wr_kind_i == 2'(b));

        if (IS_WT) begin : g_wt
          logic upd;
          assign upd   = wu_en_i && (rd_ph_q == PH);
          assign full  = (cnt[b] == CNT_W'(DEPTH));
          assign clr   = 1'b0;
          assign acc   = hit && !full && !upd;
          assign we    = acc || upd;
          assign waddr = upd ? rd_addr_o : cnt[b][ADDR_W-1:0];
          assign wdata = upd ? wu_data_i : wr_data_i;
        end else begin : g_in
          assign full  = (cnt[b] == (PH ? lim_bwd : lim_fwd));
          assign clr   = done_evt && (phase_act == PH);
          assign acc   = hit && !full;
          assign we    = acc;
          assign waddr = cnt[b][ADDR_W-1:0];
          assign wdata = wr_data_i;
        end

        nmem_wr_ptr #(.CNT_W(CNT_W)) u_ptr (
          .clk   (clk),
          .rst   (rst),
          .clr_i (clr),
          .inc_i (acc),
          .cnt_o (cnt[b])
        );

        nmem_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
          .clk     (clk),
          .we_i    (we),
          .waddr_i (waddr),
          .wdata_i (wdata),
          .re_i    (step && (phase_act == PH)),
          .raddr_i (rd_idx),
          .rdata_o (rdat[b])
        );
      end else begin : g_off
        assign cnt[b]  = '0;
        assign rdat[b] = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_o  <= 1'b0;
      done_o    <= 1'b0;
      rd_addr_o <= '0;
      rd_ph_q   <= 1'b0;
    end else begin
      rd_vld_o <= step;
      done_o   <= done_evt;
      if (step) begin
        rd_addr_o <= rd_idx;
        rd_ph_q   <= phase_act;
      end
    end
  end

  assign rd_in_o = rd_ph_q ? rdat[2] : rdat[0];
  assign rd_wt_o = rd_ph_q ? rdat[3] : rdat[1];

endmodule

// File: rtl/nmem_addr_unit_chk.sv
module nmem_addr_unit_chk #(
  parameter int ADDR_W      = 6,
  parameter bit BACKPROP_EN = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              lim_ld_i,
  input logic [ADDR_W:0]   lim_fwd_i,
  input logic [ADDR_W:0]   lim_bwd_i,
  input logic              phase_i,
  input logic              rd_req_i,
  input logic              rd_vld_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o
);
  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0]  sh_fwd, sh_bwd;
  logic              ph_now, ph_d, exp_zero;
  logic [ADDR_W-1:0] prev_addr;

  assign ph_now = BACKPROP_EN ? phase_i : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_fwd    <= '0;
      sh_bwd    <= '0;
      ph_d      <= 1'b0;
      exp_zero  <= 1'b1;
      prev_addr <= '0;
    end else begin
      if (lim_ld_i) begin
        sh_fwd <= lim_fwd_i;
        sh_bwd <= lim_bwd_i;
      end
      ph_d <= ph_now;
      if (done_o || (ph_now != ph_d)) exp_zero <= 1'b1;
      else if (rd_vld_o)              exp_zero <= 1'b0;
      if (rd_vld_o) prev_addr <= rd_addr_o;
    end
  end

  AST_VLD_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    rd_vld_o |-> $past(rd_req_i)); // R4

  AST_DONE_WITH_VLD: assert property (@(posedge clk) disable iff (rst)
    done_o |-> rd_vld_o); // R6

  AST_DONE_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (({1'b0, rd_addr_o} + CNT_W'(1)) ==
                (ph_d ? $past(sh_bwd) : $past(sh_fwd)))); // R8

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_vld_o && exp_zero) |-> (rd_addr_o == '0)); // R12

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_vld_o && !exp_zero) |-> (rd_addr_o == prev_addr + ADDR_W'(1))); // R2

endmodule

bind nmem_addr_unit nmem_addr_unit_chk #(
  .ADDR_W      (ADDR_W),
  .BACKPROP_EN (BACKPROP_EN)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .lim_ld_i  (lim_ld_i),
  .lim_fwd_i (lim_fwd_i),
  .lim_bwd_i (lim_bwd_i),
  .phase_i   (phase_i),
  .rd_req_i  (rd_req_i),
  .rd_vld_o  (rd_vld_o),
  .rd_addr_o (rd_addr_o),
  .done_o    (done_o)
);

// File: tb/nmem_addr_unit_tb_top.sv
module nmem_addr_unit_tb_top;
  localparam int DW = 16;
  localparam int AW = 4;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] wt;
    logic          done;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          wr_en = 0, lim_ld = 0, phase = 0, rd_req = 0, wu_en = 0;
  logic [1:0]    wr_kind = 0;
  logic [DW-1:0] wr_data = 0, wu_data = 0;
  logic [AW:0]   lim_f = 0, lim_b = 0;
  logic          rd_vld, done;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_in, rd_wt;

  logic          n_wr_en = 0, n_lim_ld = 0, n_rd_req = 0;
  logic [1:0]    n_wr_kind = 0;
  logic [DW-1:0] n_wr_data = 0;
  logic [AW:0]   n_lim_f = 0;
  logic          n_vld, n_done;
  logic [AW-1:0] n_addr;
  logic [DW-1:0] n_in, n_wt;

  int  n_tests = 0, n_fail = 0;
  bit  finished = 0;
  exp_t  sb_q[$];
  string tag_q[$];

  nmem_addr_unit #(.DATA_W(DW), .ADDR_W(AW), .BACKPROP_EN(1'b1)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_kind_i(wr_kind),
    .wr_data_i(wr_data), .lim_ld_i(lim_ld), .lim_fwd_i(lim_f),
    .lim_bwd_i(lim_b), .phase_i(phase), .rd_req_i(rd_req),
    .rd_vld_o(rd_vld), .rd_addr_o(rd_addr), .rd_in_o(rd_in),
    .rd_wt_o(rd_wt), .done_o(done), .wu_en_i(wu_en), .wu_data_i(wu_data)
  );

  nmem_addr_unit #(.DATA_W(DW), .ADDR_W(AW), .BACKPROP_EN(1'b0)) dut_nb_i (
    .clk(clk), .rst(rst), .wr_en_i(n_wr_en), .wr_kind_i(n_wr_kind),
    .wr_data_i(n_wr_data), .lim_ld_i(n_lim_ld), .lim_fwd_i(n_lim_f),
    .lim_bwd_i(n_lim_f), .phase_i(1'b1), .rd_req_i(n_rd_req),
    .rd_vld_o(n_vld), .rd_addr_o(n_addr), .rd_in_o(n_in),
    .rd_wt_o(n_wt), .done_o(n_done), .wu_en_i(1'b0), .wu_data_i('0)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Inputs change just after the falling edge and return to idle there
  task automatic tick();
    @(negedge clk);
    wr_en = 0; lim_ld = 0; rd_req = 0; wu_en = 0;
    n_wr_en = 0; n_lim_ld = 0; n_rd_req = 0;
  endtask

  task automatic wr(input logic [1:0] k, input logic [DW-1:0] d);
    wr_en = 1; wr_kind = k; wr_data = d;
  endtask

  // Driver: request a read that the requirements say will be granted
  task automatic rd_exp(input int a, input int din, input int wt, input bit dn,
                        input string tag);
    exp_t e;
    rd_req = 1;
    e.addr = AW'(a); e.din = DW'(din); e.wt = DW'(wt); e.done = dn;
    sb_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares every returned pair against the scoreboard
  always @(posedge clk) begin
    #2;
    if (!rst && rd_vld) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R4 unexpected rd_vld", 64'(rd_addr), 64'hffff);
      end else begin
        exp_t  e;
        string t;
        e = sb_q.pop_front();
        t = tag_q.pop_front();
        check({rd_addr, rd_in, rd_wt, done} == e, t,
              64'({rd_addr, rd_in, rd_wt, done}), 64'(e));
      end
    end else if (!rst && done) begin
      check(1'b0, "R6 done without rd_vld", 64'(done), 64'h0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check(rd_vld == 0 && done == 0, "R1 reset outputs", 64'({rd_vld, done}), 64'h0);
    check(n_vld == 0, "R1 reset outputs (no backprop)", 64'(n_vld), 64'h0);

    // R8 limits: forward 4, backward 3
    lim_ld = 1; lim_f = 4; lim_b = 3; tick();
    for (int i = 0; i < 4; i++) begin wr(2'd1, DW'(16'h200 + i)); tick(); end
    for (int i = 0; i < 3; i++) begin wr(2'd2, DW'(16'h400 + i)); tick(); end
    for (int i = 0; i < 3; i++) begin wr(2'd3, DW'(16'h500 + i)); tick(); end

    // R3: no forward input yet, requests must stall
    rd_req = 1; tick();
    check(rd_vld == 0, "R3 stall on empty input bank", 64'(rd_vld), 64'h0);
    rd_req = 1; tick();
    check(rd_vld == 0, "R3 stall on empty input bank", 64'(rd_vld), 64'h0);

    // R5: writes and reads interleaved, R2 pairing, R6 done at entry 3
    wr(2'd0, 16'h100); tick();
    wr(2'd0, 16'h101); rd_exp(0, 16'h100, 16'h200, 0, "R5 concurrent read 0"); tick();
    wr(2'd0, 16'h102); rd_exp(1, 16'h101, 16'h201, 0, "R5 concurrent read 1"); tick();
    wr(2'd0, 16'h103); rd_exp(2, 16'h102, 16'h202, 0, "R2 pair order 2"); tick();
    rd_exp(3, 16'h103, 16'h203, 1, "R6 done at last forward entry"); tick();

    // R9: update entry 3, same-cycle bus weight write is dropped
    wu_en = 1; wu_data = 16'hABC; wr(2'd1, 16'h999); tick();
    wr(2'd1, 16'h2FF); tick();

    // R6 input pointer cleared; R7 overflowing input write ignored
    for (int i = 0; i < 4; i++) begin wr(2'd0, DW'(16'h300 + i)); tick(); end
    wr(2'd0, 16'h3EE); tick();
    lim_ld = 1; lim_f = 5; lim_b = 3; tick();
    rd_exp(0, 16'h300, 16'h200, 0, "R6 second pass restarts at 0"); tick();
    rd_exp(1, 16'h301, 16'h201, 0, "R8 reloaded limit, no early done"); tick();
    rd_exp(2, 16'h302, 16'h202, 0, "R2 pair order second pass"); tick();
    rd_exp(3, 16'h303, 16'hABC, 0, "R9 updated weight read back"); tick();
    rd_req = 1; tick();
    check(rd_vld == 0, "R7 input write past limit was ignored", 64'(rd_vld), 64'h0);
    wr(2'd0, 16'h304); tick();
    rd_exp(4, 16'h304, 16'h2FF, 1, "R9 dropped bus write kept pointer"); tick();

    // R12: partial forward read, then phase change resets counter
    wr(2'd0, 16'h600); tick();
    rd_exp(0, 16'h600, 16'h200, 0, "R12 partial forward read"); tick();
    phase = 1; tick();
    rd_exp(0, 16'h400, 16'h500, 0, "R12 counter reset on phase change"); tick();
    rd_exp(1, 16'h401, 16'h501, 0, "R10 backward pair 1"); tick();
    rd_exp(2, 16'h402, 16'h502, 1, "R10 backward done at backward limit"); tick();
    wu_en = 1; wu_data = 16'hBBB; tick();
    for (int i = 0; i < 3; i++) begin wr(2'd2, DW'(16'h700 + i)); tick(); end
    rd_exp(0, 16'h700, 16'h500, 0, "R10 backward second pass"); tick();
    rd_exp(1, 16'h701, 16'h501, 0, "R10 backward second pass"); tick();
    rd_exp(2, 16'h702, 16'hBBB, 1, "R9 backward weight update"); tick();

    // R11: instance without backward banks
    n_lim_ld = 1; n_lim_f = 2; tick();
    n_wr_en = 1; n_wr_kind = 2'd1; n_wr_data = 16'h210; tick();
    n_wr_en = 1; n_wr_kind = 2'd3; n_wr_data = 16'h999; tick();
    n_wr_en = 1; n_wr_kind = 2'd0; n_wr_data = 16'h110; tick();
    n_wr_en = 1; n_wr_kind = 2'd2; n_wr_data = 16'h888; tick();
    n_wr_en = 1; n_wr_kind = 2'd1; n_wr_data = 16'h211; tick();
    n_wr_en = 1; n_wr_kind = 2'd0; n_wr_data = 16'h111; tick();
    n_rd_req = 1; tick();
    check(n_vld && n_addr == 0 && n_in == 16'h110 && n_wt == 16'h210 && !n_done,
          "R11 forward pair with phase ignored", 64'({n_vld, n_addr, n_in, n_wt, n_done}),
          64'({1'b1, 4'd0, 16'h110, 16'h210, 1'b0}));
    n_rd_req = 1; tick();
    check(n_vld && n_addr == 1 && n_in == 16'h111 && n_wt == 16'h211 && n_done,
          "R11 kinds 2 and 3 ignored", 64'({n_vld, n_addr, n_in, n_wt, n_done}),
          64'({1'b1, 4'd1, 16'h111, 16'h211, 1'b1}));

    repeat (3) tick();
    check(sb_q.size() == 0, "R4 all granted reads returned", 64'(sb_q.size()), 64'h0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule